// File: doc/BRIEF.md
# Keyboard Controller Register Interface

This block sits between a processor's memory-mapped I/O space and a keyboard. Software sees a byte-wide status/command offset and a data offset. It polls the status byte, reads scancodes from the data offset, and writes command bytes to the command offset. The keyboard side uses two byte handshakes. One carries scancodes in from the keyboard. The other carries bytes out to the keyboard, such as keyboard commands and LED state.

A small decoder runs as a state machine with five states:

| State | What happens | Transitions |
|---|---|---|
| ST_IDLE | Waits for a pending host byte | Goes to ST_DECODE when the input-buffer flag is set |
| ST_DECODE | Accepts the pending byte and clears the input-buffer flag | A self-test command goes to ST_TEST; any other command returns to ST_IDLE; a data byte goes to ST_SEND |
| ST_TEST | Counts out the self-test time | Goes to ST_RESULT when the counter reaches zero |
| ST_RESULT | Holds the pass byte until the output buffer is empty | Loads the pass byte and returns to ST_IDLE once the output buffer is empty |
| ST_SEND | Presents a byte to the keyboard | Returns to ST_IDLE on the keyboard's ready |

Three commands are understood: keyboard enable, self test, and LED set. LED set arms the next data write so that the byte becomes the LED state. An interrupt output can mirror the output-buffer flag.

Top module: `kbc_regif`

## Requirements
- R1: Reset clears status, LED state and outputs. A read at offset 0x64 returns the status byte: bit 0 output buffer full, bit 1 input buffer full, bit 2 self test passed, bit 3 last accepted write went to the command offset, bit 4 keyboard enabled, bits 7..5 zero. A read at offset 0x60 returns the data register. Any other offset reads 0x00.
- R2: While the keyboard is enabled and the output buffer is empty, kbd_ready is high. A scancode handed over on a clock edge appears in the data register, and the output-buffer flag is set from that edge on.
- R3: While the output-buffer flag is set and the keyboard is enabled, kbd_ready is low, so the next scancode is held off and later delivered in order. A read strobe at offset 0x60 clears the flag on its edge.
- R4: A write to 0x60 or 0x64 while the input-buffer flag is clear is captured on its edge, and the flag is set. The decoder accepts the byte and clears the flag two edges after capture. A write made while the flag is set is dropped.
- R5: The keyboard is disabled after reset. While disabled, kbd_ready is high and scancodes are consumed and discarded. Command 0xAE enables the keyboard.
- R6: After command 0xAA, byte 0x55 is loaded into the data register, with the output-buffer flag and the self-test flag set, TEST_CYCLES+3 edges after capture. If the output buffer is still full, loading waits until software empties it.
- R7: Command 0xED arms the decoder. The next data write becomes led_state and is also sent to the keyboard.
- R8: A data write that is not armed is sent to the keyboard unchanged. dev_valid rises two edges after capture and holds with a stable dev_byte until dev_ready.
- R9: An unknown command byte changes nothing except status bit 3. In particular it leaves the LED arm, the LED state and the keyboard enable as they were.
- R10: irq is high exactly when irq_enable is high and the output-buffer flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Host access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Host offset |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Host read byte (combinational) |
| irq_enable | input | 1 | Lets irq follow the output buffer |
| irq | output | 1 | Scancode-waiting interrupt |
| kbd_valid | input | 1 | Keyboard offers a scancode |
| kbd_code | input | 8 | Offered scancode |
| kbd_ready | output | 1 | Controller takes the scancode on this edge |
| dev_valid | output | 1 | Byte for the keyboard is present |
| dev_byte | output | 8 | Byte for the keyboard |
| dev_ready | input | 1 | Keyboard takes dev_byte on this edge |
| led_state | output | 8 | Last LED byte written |

## Verification
Reads are combinational, so read values are checked in the same cycle in which the offset is driven. A write is captured on edge 0, and the input-buffer flag is checked just after that edge. Its effects (enable, LED state, dev_valid) are checked just after edge 2, and the self-test byte just after edge TEST_CYCLES+3, with the output-buffer flag also checked still clear one edge earlier. Scancode hand-overs take effect on the edge that completes them and are sampled at the following falling edge. The bench drives all inputs and samples all outputs at falling clock edges.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SELF_TEST = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_KBD_ON    = 8'hAE;
    localparam logic [BYTE_W-1:0] CMD_LED_SET   = 8'hED;
    localparam logic [BYTE_W-1:0] TEST_PASS     = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_TEST,
        ST_RESULT,
        ST_SEND
    } ctl_state_t;

    typedef struct packed {
        logic [2:0] zero;
        logic       kb_on;
        logic       last_cmd;
        logic       sys_ok;
        logic       ibs;
        logic       obs;
    } status_t;
endpackage

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              accept,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              ibs,
    output logic [BYTE_W-1:0] pend_byte,
    output logic              pend_is_cmd,
    output logic              last_cmd,
    output logic              data_rd
);
    logic hit_data;
    logic hit_ctrl;
    logic wr_hit;

    assign hit_data = (cpu_addr == DATA_OFF);
    assign hit_ctrl = (cpu_addr == CTRL_OFF);
    assign wr_hit   = cpu_sel && cpu_wr && (hit_data || hit_ctrl);
    assign data_rd  = cpu_sel && !cpu_wr && hit_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibs         <= 1'b0;
            pend_byte   <= '0;
            pend_is_cmd <= 1'b0;
            last_cmd    <= 1'b0;
        end else if (accept) begin
            ibs <= 1'b0;
        end else if (wr_hit && !ibs) begin
            ibs         <= 1'b1;
            pend_byte   <= cpu_wdata;
            pend_is_cmd <= hit_ctrl;
            last_cmd    <= hit_ctrl;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (hit_ctrl) begin
            cpu_rdata = status_byte;
        end else if (hit_data) begin
            cpu_rdata = data_byte;
        end
    end
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_on,
    input  logic              kbd_valid,
    input  logic [BYTE_W-1:0] kbd_code,
    input  logic              result_hold,
    input  logic              load_pass,
    input  logic              data_rd,
    input  logic              irq_enable,
    output logic              kbd_ready,
    output logic              obs,
    output logic [BYTE_W-1:0] data_q,
    output logic              irq
);
    logic take;

    assign kbd_ready = kb_on ? (!obs && !result_hold) : 1'b1;
    assign take      = kbd_valid && kbd_ready && kb_on;
    assign irq       = irq_enable && obs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obs    <= 1'b0;
            data_q <= '0;
        end else if (load_pass) begin
            obs    <= 1'b1;
            data_q <= TEST_PASS;
        end else if (take) begin
            obs    <= 1'b1;
            data_q <= kbd_code;
        end else if (data_rd) begin
            obs <= 1'b0;
        end
    end
endmodule

// File: rtl/kbc_ctl_fsm.sv
module kbc_ctl_fsm
    import kbc_pkg::*;
#(
    parameter int TEST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibs,
    input  logic [BYTE_W-1:0] pend_byte,
    input  logic              pend_is_cmd,
    input  logic              obs,
    input  logic              dev_ready,
    output logic              accept,
    output logic              load_pass,
    output logic              result_hold,
    output logic              kb_on,
    output logic              sys_ok,
    output logic [BYTE_W-1:0] led_state,
    output logic              dev_valid,
    output logic [BYTE_W-1:0] dev_byte
);
    localparam int CNT_W = $clog2(TEST_CYCLES + 1);

    ctl_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic led_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (ibs) state_nx = ST_DECODE;
            ST_DECODE: begin
                if (!pend_is_cmd)                    state_nx = ST_SEND;
                else if (pend_byte == CMD_SELF_TEST) state_nx = ST_TEST;
                else                                 state_nx = ST_IDLE;
            end
            ST_TEST:   if (cnt == '0) state_nx = ST_RESULT;
            ST_RESULT: if (!obs) state_nx = ST_IDLE;
            ST_SEND:   if (dev_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            kb_on     <= 1'b0;
            sys_ok    <= 1'b0;
            led_armed <= 1'b0;
            led_state <= '0;
            dev_byte  <= '0;
        end else begin
            unique case (state)
                ST_DECODE: begin
                    if (pend_is_cmd) begin
                        if (pend_byte == CMD_KBD_ON)    kb_on     <= 1'b1;
                        if (pend_byte == CMD_LED_SET)   led_armed <= 1'b1;
                        if (pend_byte == CMD_SELF_TEST) cnt <= CNT_W'(TEST_CYCLES - 1);
                    end else begin
                        dev_byte <= pend_byte;
                        if (led_armed) begin
                            led_state <= pend_byte;
                            led_armed <= 1'b0;
                        end
                    end
                end
                ST_TEST:   if (cnt != '0) cnt <= cnt - 1'b1;
                ST_RESULT: if (!obs) sys_ok <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign accept      = (state == ST_DECODE);
    assign result_hold = (state == ST_RESULT);
    assign load_pass   = (state == ST_RESULT) && !obs;
    assign dev_valid   = (state == ST_SEND);
endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
    import kbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h64,
    parameter int TEST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              irq_enable,
    output logic              irq,
    input  logic              kbd_valid,
    input  logic [7:0]        kbd_code,
    output logic              kbd_ready,
    output logic              dev_valid,
    output logic [7:0]        dev_byte,
    input  logic              dev_ready,
    output logic [7:0]        led_state
);
    logic              ibs, obs, kb_on, sys_ok, last_cmd;
    logic              accept, load_pass, result_hold, data_rd, pend_is_cmd;
    logic [BYTE_W-1:0] pend_byte, data_q;
    status_t           status;

    assign status = '{zero: 3'b000, kb_on: kb_on, last_cmd: last_cmd,
                      sys_ok: sys_ok, ibs: ibs, obs: obs};

    kbc_host_if #(.ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .CTRL_OFF(CTRL_OFF)) i_host (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .status_byte(status),
        .data_byte(data_q), .accept(accept), .cpu_rdata(cpu_rdata), .ibs(ibs),
        .pend_byte(pend_byte), .pend_is_cmd(pend_is_cmd), .last_cmd(last_cmd),
        .data_rd(data_rd)
    );

    kbc_out_buf i_obuf (
        .clk(clk), .rst_n(rst_n), .kb_on(kb_on), .kbd_valid(kbd_valid),
        .kbd_code(kbd_code), .result_hold(result_hold), .load_pass(load_pass),
        .data_rd(data_rd), .irq_enable(irq_enable), .kbd_ready(kbd_ready),
        .obs(obs), .data_q(data_q), .irq(irq)
    );

    kbc_ctl_fsm #(.TEST_CYCLES(TEST_CYCLES)) i_fsm (
        .clk(clk), .rst_n(rst_n), .ibs(ibs), .pend_byte(pend_byte),
        .pend_is_cmd(pend_is_cmd), .obs(obs), .dev_ready(dev_ready),
        .accept(accept), .load_pass(load_pass), .result_hold(result_hold),
        .kb_on(kb_on), .sys_ok(sys_ok), .led_state(led_state),
        .dev_valid(dev_valid), .dev_byte(dev_byte)
    );
endmodule

// File: rtl/kbc_regif_chk.sv
module kbc_regif_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFF = 8'h60,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              kbd_valid,
    input logic [7:0]        kbd_code,
    input logic              kbd_ready,
    input logic              dev_valid,
    input logic [7:0]        dev_byte,
    input logic              dev_ready,
    input logic              obs,
    input logic              ibs,
    input logic              kb_on,
    input logic [7:0]        data_q
);
    a_r2_take_code: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid && kbd_ready && kb_on |=> obs && (data_q == $past(kbd_code)));

    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        obs && kb_on |-> !kbd_ready);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_wr && (cpu_addr == DATA_OFF) && obs |=> !obs);

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && cpu_wr && ((cpu_addr == DATA_OFF) || (cpu_addr == CTRL_OFF)) && !ibs |=> ibs);

    a_r8_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_ready |=> dev_valid && $stable(dev_byte));
endmodule

bind kbc_regif kbc_regif_chk #(.ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .CTRL_OFF(CTRL_OFF)) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .kbd_valid(kbd_valid), .kbd_code(kbd_code), .kbd_ready(kbd_ready),
    .dev_valid(dev_valid), .dev_byte(dev_byte), .dev_ready(dev_ready),
    .obs(obs), .ibs(ibs), .kb_on(kb_on), .data_q(data_q)
);

// File: tb/test_kbc_regif.sv
module test_kbc_regif;
    localparam int PERIOD = 10;
    localparam int TCYC = 8;
    localparam logic [7:0] DOFF = 8'h60;
    localparam logic [7:0] COFF = 8'h64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_addr = 8'h00, cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic irq_enable = 1'b1, irq;
    logic kbd_valid = 1'b0;
    logic [7:0] kbd_code = 8'h00;
    logic kbd_ready, dev_valid, dev_ready = 1'b0;
    logic [7:0] dev_byte, led_state;

    int checks = 0;
    int fails = 0;

    kbc_regif #(.TEST_CYCLES(TCYC)) i_kbc_regif (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_enable(irq_enable), .irq(irq), .kbd_valid(kbd_valid),
        .kbd_code(kbd_code), .kbd_ready(kbd_ready), .dev_valid(dev_valid),
        .dev_byte(dev_byte), .dev_ready(dev_ready), .led_state(led_state)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_status(bit kb, bit lc, bit sys, bit ib, bit ob);
        return {3'b000, kb, lc, sys, ib, ob};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_sel = 1'b1; cpu_wr = 1'b1;
        step();
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic peek(logic [7:0] a, output logic [7:0] v);
        cpu_sel = 1'b0; cpu_addr = a;
        #1 v = cpu_rdata;
    endtask

    task automatic pop_data(output logic [7:0] v);
        cpu_addr = DOFF; cpu_sel = 1'b1; cpu_wr = 1'b0;
        #1 v = cpu_rdata;
        step();
        cpu_sel = 1'b0;
    endtask

    task automatic send_code(logic [7:0] c);
        kbd_valid = 1'b1; kbd_code = c;
        step();
        kbd_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_code;
        int ndev;
        void'($urandom(32'h5eed_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        peek(COFF, v); chk("R1 reset status", v, 8'h00);
        peek(8'h10, v); chk("R1 other offset", v, 8'h00);
        chk("R1 reset led", led_state, 8'h00);
        chk("R1 reset dev_valid", {7'b0, dev_valid}, 8'h00);
        chk("R5 disabled ready", {7'b0, kbd_ready}, 8'h01);

        send_code(8'h1C);
        peek(COFF, v); chk("R5 disabled discards", v, 8'h00);

        wr(COFF, 8'hAE);
        peek(COFF, v); chk("R4 ibs after capture", v, exp_status(0, 1, 0, 1, 0));
        step(); step();
        peek(COFF, v); chk("R5 enabled", v, exp_status(1, 1, 0, 0, 0));

        send_code(8'h2A);
        peek(COFF, v); chk("R2 obs set", v, exp_status(1, 1, 0, 0, 1));
        chk("R10 irq on", {7'b0, irq}, 8'h01);
        kbd_valid = 1'b1; kbd_code = 8'h3B;
        #1 chk("R3 held off", {7'b0, kbd_ready}, 8'h00);
        step(); step();
        pop_data(v); chk("R2 scancode", v, 8'h2A);
        #1 chk("R3 ready after read", {7'b0, kbd_ready}, 8'h01);
        step();
        kbd_valid = 1'b0;
        pop_data(v); chk("R3 held code kept", v, 8'h3B);
        peek(COFF, v); chk("R3 obs cleared", v, exp_status(1, 1, 0, 0, 0));

        irq_enable = 1'b0;
        send_code(8'h44);
        #1 chk("R10 irq masked", {7'b0, irq}, 8'h00);
        pop_data(v);
        irq_enable = 1'b1;

        wr(COFF, 8'hAA);
        repeat (TCYC + 2) step();
        peek(COFF, v); chk("R6 not yet", {7'b0, v[0]}, 8'h00);
        step();
        peek(COFF, v); chk("R6 pass status", v, exp_status(1, 1, 1, 0, 1));
        pop_data(v); chk("R6 pass byte", v, 8'h55);

        send_code(8'h5A);
        wr(COFF, 8'hAA);
        repeat (TCYC + 6) step();
        pop_data(v); chk("R6 waits for obs", v, 8'h5A);
        step();
        peek(COFF, v); chk("R6 late pass obs", {7'b0, v[0]}, 8'h01);
        pop_data(v); chk("R6 late pass byte", v, 8'h55);

        dev_ready = 1'b0;
        wr(COFF, 8'hED); step(); step();
        chk("R7 arm sends nothing", {7'b0, dev_valid}, 8'h00);
        wr(DOFF, 8'h05); step(); step();
        chk("R7 led set", led_state, 8'h05);
        chk("R7 led sent", dev_byte, 8'h05);
        step(); step(); step();
        chk("R8 held valid", {7'b0, dev_valid}, 8'h01);
        dev_ready = 1'b1;
        step();
        chk("R8 released", {7'b0, dev_valid}, 8'h00);

        wr(DOFF, 8'hF4); step(); step();
        chk("R8 unarmed sent", dev_byte, 8'hF4);
        chk("R9 led unchanged", led_state, 8'h05);
        step();

        wr(DOFF, 8'h11);
        wr(DOFF, 8'h22);
        ndev = 0;
        for (int i = 0; i < 12; i++) begin
            if (dev_valid) begin
                ndev++;
                chk("R4 first kept", dev_byte, 8'h11);
            end
            step();
        end
        chk("R4 second dropped", 8'(ndev), 8'h01);

        wr(COFF, 8'hED); step(); step();
        wr(COFF, 8'h12); step(); step();
        peek(COFF, v); chk("R9 unknown status", v, exp_status(1, 1, 1, 0, 0));
        chk("R9 no send", {7'b0, dev_valid}, 8'h00);
        wr(DOFF, 8'h09); step(); step();
        chk("R9 arm survives", led_state, 8'h09);
        step();

        exp_code = 8'h00;
        for (int i = 0; i < 400; i++) begin
            bit hs;
            logic [7:0] st;
            if (!kbd_valid && ($urandom % 3 == 0)) begin
                kbd_valid = 1'b1;
                kbd_code = 8'($urandom);
            end
            peek(COFF, st);
            if (st[0]) chk("R3 random hold", {7'b0, kbd_ready}, 8'h00);
            hs = kbd_valid && kbd_ready;
            if (st[0] && ($urandom % 2 == 1)) begin
                chk("R10 random irq", {7'b0, irq}, 8'h01);
                cpu_addr = DOFF; cpu_sel = 1'b1;
                #1 chk("R2 random code", cpu_rdata, exp_code);
            end
            if (hs) exp_code = kbd_code;
            step();
            cpu_sel = 1'b0;
            if (hs) kbd_valid = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule